// File: doc/BRIEF.md
# Link Rate Predictor and Step Controller

This block sits beside one router output port and decides, once per fixed observation window, whether the serial links behind that port should step one level faster, one level slower, or stay where they are. During each window it counts the router cycles in which a flit crossed the link. It also adds up the occupancy of the downstream input buffer, which the port already tracks through its credit count. It uses only these local measurements and exchanges no information with other ports.

At the last cycle of a window the block turns both totals into fractions of one. Link utilization is normalized by the current router-to-link clock divisor, and buffer utilization is normalized by the buffer capacity. It then blends each fraction with its earlier prediction, giving the new sample a weight of three and the earlier prediction a weight of one. The blend uses only a shift and two adds.

The smoothed buffer figure acts as a congestion detector. When the buffer is mostly empty, the block uses the light-load threshold pair. When the buffer is mostly full, it uses the congested pair, whose higher values cut link power more aggressively because the added link delay is hidden behind queueing. All thresholds are inputs, so software or a neighbouring block can set them. The link sequencer receives a one-cycle request that carries the chosen direction.

Top module: `link_dvs_ctrl`

## Requirements
- R1: `req_valid` is high for exactly one clock per window. The first pulse comes WIN_CYCLES clocks after reset is released, and each later pulse comes WIN_CYCLES clocks after the previous one.
- R2: The current link utilization is floor(busy × link_div × 256 / WIN_CYCLES). Here busy is the number of window cycles with `link_flit` high, and link_div is the value present in the last cycle of the window.
- R3: The current buffer utilization is floor(S × 256 / (WIN_CYCLES × BUF_CAP)). Here S is the sum over the window of `buf_occ`, with each sample clamped to BUF_CAP.
- R4: Each prediction becomes floor((3 × current + previous) / 4) at the window boundary. Both predictions reset to 0 and change at no other time. `lu_pred` and `bu_pred` show the stored values.
- R5: `congested` is 1 when the new buffer prediction is at least `thr_cong`. In that case `thr_lo_cong`/`thr_hi_cong` apply; otherwise `thr_lo_light`/`thr_hi_light` apply. Threshold values are taken from the last cycle of the window.
- R6: With the request, `step_slower` is 1 if the new link prediction is below the low threshold. Otherwise `step_faster` is 1 if it is above the high threshold. Otherwise both are 0. Neither output is ever high without `req_valid`.
- R7: Both accumulators clear at the boundary, so the totals of one window do not carry into the next.
- R8: The link utilization saturates at 256 (1.0) when busy × link_div exceeds the window length. Neither prediction ever exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_flit | input | 1 | High in a cycle in which a flit crosses the link |
| buf_occ | input | 8 | Occupied downstream buffer slots (credit-derived) |
| link_div | input | 4 | Router cycles per link cycle, 1 or more |
| thr_cong | input | 9 | Congestion level for buffer prediction (fraction, 8 fractional bits) |
| thr_lo_light | input | 9 | Low threshold, light load |
| thr_hi_light | input | 9 | High threshold, light load |
| thr_lo_cong | input | 9 | Low threshold, congested |
| thr_hi_cong | input | 9 | High threshold, congested |
| req_valid | output | 1 | One-cycle decision strobe per window |
| step_faster | output | 1 | Request one level faster (with `req_valid`) |
| step_slower | output | 1 | Request one level slower (with `req_valid`) |
| congested | output | 1 | Threshold pair used at the last decision |
| lu_pred | output | 9 | Stored link utilization prediction |
| bu_pred | output | 9 | Stored buffer utilization prediction |

## Verification
Every result of a window is registered on the clock edge that ends its last cycle, so the strobe, both predictions, the congestion flag and the direction are all due one clock after the last input sample. The bench drives each sample on a falling edge and checks the boundary results on the falling edge right after that closing edge, before it drives the first sample of the next window. On every other falling edge inside a window it checks that no strobe is present.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int FRAC = 8;
  localparam int UW   = FRAC + 1;

  typedef logic [UW-1:0] frac_t;
  localparam frac_t ONE = {1'b1, {FRAC{1'b0}}};

  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_SLOWER = 2'd1,
    STEP_FASTER = 2'd2
  } step_e;

  // (3*cur + prev) / 4 using one shift and two adds
  function automatic frac_t ewma_w3(frac_t cur, frac_t prev);
    logic [UW+1:0] acc;
    acc = {1'b0, cur, 1'b0} + {2'b00, cur} + {2'b00, prev};
    return acc[UW+1:2];
  endfunction

  function automatic step_e pick_step(frac_t lu, frac_t lo, frac_t hi);
    if (lu < lo) return STEP_SLOWER;
    if (lu > hi) return STEP_FASTER;
    return STEP_HOLD;
  endfunction
endpackage

// File: rtl/dvs_hist_acc.sv
module dvs_hist_acc #(
  parameter int WIN = 200,
  parameter int CAP = 128,
  localparam int CNT_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int BUSY_W = $clog2(WIN + 1),
  localparam int OCC_W  = $clog2(CAP + 1),
  localparam int SUM_W  = $clog2(WIN * CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_flit,
  input  logic [OCC_W-1:0]  occ,
  output logic              win_end,
  output logic [BUSY_W-1:0] busy_tot,
  output logic [SUM_W-1:0]  occ_tot
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BUSY_W-1:0] busy_q;
  logic [SUM_W-1:0]  occ_q;
  logic [OCC_W-1:0]  occ_c;

  assign occ_c    = (occ > OCC_W'(CAP)) ? OCC_W'(CAP) : occ;
  assign win_end  = (cnt_q == CNT_W'(WIN - 1));
  assign busy_tot = busy_q + BUSY_W'(link_flit);
  assign occ_tot  = occ_q + SUM_W'(occ_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= '0;
      occ_q  <= '0;
    end else if (win_end) begin
      cnt_q  <= '0;
      busy_q <= '0;
      occ_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      busy_q <= busy_tot;
      occ_q  <= occ_tot;
    end
  end
endmodule

// File: rtl/dvs_util_calc.sv
module dvs_util_calc
  import dvs_pkg::*;
#(
  parameter int WIN   = 200,
  parameter int CAP   = 128,
  parameter int DIV_W = 4,
  localparam int BUSY_W = $clog2(WIN + 1),
  localparam int SUM_W  = $clog2(WIN * CAP + 1),
  localparam int LW     = BUSY_W + DIV_W + FRAC,
  localparam int BW     = SUM_W + FRAC
) (
  input  logic [BUSY_W-1:0] busy_tot,
  input  logic [SUM_W-1:0]  occ_tot,
  input  logic [DIV_W-1:0]  link_div,
  output frac_t             lu_cur,
  output frac_t             bu_cur
);
  function automatic frac_t link_frac(logic [BUSY_W-1:0] b, logic [DIV_W-1:0] d);
    logic [LW-1:0] num;
    logic [LW-1:0] q;
    num = (LW'(b) * LW'(d)) << FRAC;
    q   = num / LW'(WIN);
    return (q > LW'(ONE)) ? ONE : q[UW-1:0];
  endfunction

  function automatic frac_t buf_frac(logic [SUM_W-1:0] s);
    logic [BW-1:0] num;
    logic [BW-1:0] q;
    num = BW'(s) << FRAC;
    q   = num / BW'(WIN * CAP);
    return (q > BW'(ONE)) ? ONE : q[UW-1:0];
  endfunction

  assign lu_cur = link_frac(busy_tot, link_div);
  assign bu_cur = buf_frac(occ_tot);
endmodule

// File: rtl/dvs_ewma_bank.sv
module dvs_ewma_bank
  import dvs_pkg::*;
#(
  parameter int N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  frac_t [N-1:0]   cur,
  output frac_t [N-1:0]   pred,
  output frac_t [N-1:0]   pred_nxt
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    frac_t pred_q;
    assign pred_nxt[g] = ewma_w3(cur[g], pred_q);
    assign pred[g]     = pred_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pred_q <= '0;
      else if (upd) pred_q <= pred_nxt[g];
    end
  end
endmodule

// File: rtl/dvs_decide.sv
module dvs_decide
  import dvs_pkg::*;
(
  input  frac_t lu_nxt,
  input  frac_t bu_nxt,
  input  frac_t thr_cong,
  input  frac_t thr_lo_light,
  input  frac_t thr_hi_light,
  input  frac_t thr_lo_cong,
  input  frac_t thr_hi_cong,
  output logic  cong_nxt,
  output step_e step_nxt
);
  frac_t lo_sel;
  frac_t hi_sel;

  assign cong_nxt = (bu_nxt >= thr_cong);
  assign lo_sel   = cong_nxt ? thr_lo_cong : thr_lo_light;
  assign hi_sel   = cong_nxt ? thr_hi_cong : thr_hi_light;
  assign step_nxt = pick_step(lu_nxt, lo_sel, hi_sel);
endmodule

// File: rtl/link_dvs_ctrl.sv
module link_dvs_ctrl
  import dvs_pkg::*;
#(
  parameter int WIN_CYCLES = 200,
  parameter int BUF_CAP    = 128,
  parameter int DIV_W      = 4,
  localparam int OCC_W  = $clog2(BUF_CAP + 1),
  localparam int BUSY_W = $clog2(WIN_CYCLES + 1),
  localparam int SUM_W  = $clog2(WIN_CYCLES * BUF_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_flit,
  input  logic [OCC_W-1:0] buf_occ,
  input  logic [DIV_W-1:0] link_div,
  input  logic [UW-1:0]    thr_cong,
  input  logic [UW-1:0]    thr_lo_light,
  input  logic [UW-1:0]    thr_hi_light,
  input  logic [UW-1:0]    thr_lo_cong,
  input  logic [UW-1:0]    thr_hi_cong,
  output logic             req_valid,
  output logic             step_faster,
  output logic             step_slower,
  output logic             congested,
  output logic [UW-1:0]    lu_pred,
  output logic [UW-1:0]    bu_pred
);
  logic              win_end;
  logic [BUSY_W-1:0] busy_tot;
  logic [SUM_W-1:0]  occ_tot;
  frac_t             lu_cur, bu_cur;
  frac_t [1:0]       cur_v, pred_v, nxt_v;
  logic              cong_nxt;
  step_e             step_nxt;
  step_e             step_q;
  logic              valid_q, cong_q;

  dvs_hist_acc #(.WIN(WIN_CYCLES), .CAP(BUF_CAP)) acc_i (
    .clk(clk), .rst_n(rst_n), .link_flit(link_flit), .occ(buf_occ),
    .win_end(win_end), .busy_tot(busy_tot), .occ_tot(occ_tot)
  );

  dvs_util_calc #(.WIN(WIN_CYCLES), .CAP(BUF_CAP), .DIV_W(DIV_W)) calc_i (
    .busy_tot(busy_tot), .occ_tot(occ_tot), .link_div(link_div),
    .lu_cur(lu_cur), .bu_cur(bu_cur)
  );

  assign cur_v = {bu_cur, lu_cur};

  dvs_ewma_bank #(.N(2)) ewma_i (
    .clk(clk), .rst_n(rst_n), .upd(win_end),
    .cur(cur_v), .pred(pred_v), .pred_nxt(nxt_v)
  );

  dvs_decide dec_i (
    .lu_nxt(nxt_v[0]), .bu_nxt(nxt_v[1]),
    .thr_cong(thr_cong), .thr_lo_light(thr_lo_light), .thr_hi_light(thr_hi_light),
    .thr_lo_cong(thr_lo_cong), .thr_hi_cong(thr_hi_cong),
    .cong_nxt(cong_nxt), .step_nxt(step_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      step_q  <= STEP_HOLD;
      cong_q  <= 1'b0;
    end else begin
      valid_q <= win_end;
      step_q  <= win_end ? step_nxt : STEP_HOLD;
      if (win_end) cong_q <= cong_nxt;
    end
  end

  assign req_valid   = valid_q;
  assign step_faster = (step_q == STEP_FASTER);
  assign step_slower = (step_q == STEP_SLOWER);
  assign congested   = cong_q;
  assign lu_pred     = pred_v[0];
  assign bu_pred     = pred_v[1];
endmodule

// File: rtl/link_dvs_ctrl_chk.sv
module link_dvs_ctrl_chk
  import dvs_pkg::*;
#(
  parameter int WIN = 200,
  localparam int GW = $clog2(WIN + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_end,
  input logic          req_valid,
  input logic          step_faster,
  input logic          step_slower,
  input logic          congested,
  input logic [UW-1:0] lu_pred,
  input logic [UW-1:0] bu_pred
);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= '0;
    else if (req_valid) gap_q <= GW'(1);
    else                gap_q <= gap_q + GW'(1);
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (gap_q == GW'(WIN)));
  assert_gap_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (gap_q < GW'(WIN)));
  assert_boundary_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> req_valid);
  assert_pred_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(lu_pred) && $stable(bu_pred) && $stable(congested)));
  assert_one_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_faster && step_slower));
  assert_step_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_faster || step_slower) |-> req_valid);
  assert_pred_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_pred <= ONE) && (bu_pred <= ONE));
endmodule

bind link_dvs_ctrl link_dvs_ctrl_chk #(.WIN(WIN_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .req_valid(req_valid),
  .step_faster(step_faster), .step_slower(step_slower), .congested(congested),
  .lu_pred(lu_pred), .bu_pred(bu_pred)
);

// File: tb/link_dvs_ctrl_tb_top.sv
module link_dvs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 200;
  localparam int CAP  = 128;
  localparam int UNIT = 256;
  localparam int NWIN = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       link_flit;
  logic [7:0] buf_occ;
  logic [3:0] link_div;
  logic [8:0] thr_cong, thr_lo_light, thr_hi_light, thr_lo_cong, thr_hi_cong;
  logic       req_valid, step_faster, step_slower, congested;
  logic [8:0] lu_pred, bu_pred;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_dvs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .link_flit(link_flit), .buf_occ(buf_occ),
    .link_div(link_div), .thr_cong(thr_cong), .thr_lo_light(thr_lo_light),
    .thr_hi_light(thr_hi_light), .thr_lo_cong(thr_lo_cong), .thr_hi_cong(thr_hi_cong),
    .req_valid(req_valid), .step_faster(step_faster), .step_slower(step_slower),
    .congested(congested), .lu_pred(lu_pred), .bu_pred(bu_pred)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_lu = 0, m_bu = 0, m_cong = 0, m_fast = 0, m_slow = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sample_lu(int busy, int div);
    int scaled = busy * div;
    if (scaled >= WIN) return UNIT;
    return (scaled * UNIT) / WIN;
  endfunction

  function automatic int sample_bu(int sum);
    return (sum * UNIT) / (WIN * CAP);
  endfunction

  function automatic int blend(int cur, int prev);
    return (cur + cur + cur + prev) / 4;
  endfunction

  task automatic check_boundary();
    check("R1", "req_valid at boundary", int'(req_valid), 1);
    check("R2 R4 R7 R8", "lu_pred", int'(lu_pred), m_lu);
    check("R3 R4 R7", "bu_pred", int'(bu_pred), m_bu);
    check("R5", "congested", int'(congested), m_cong);
    check("R6", "step_faster", int'(step_faster), m_fast);
    check("R6", "step_slower", int'(step_slower), m_slow);
  endtask

  task automatic set_default_thr();
    thr_cong = 9'd128; thr_lo_light = 9'd77; thr_hi_light = 9'd102;
    thr_lo_cong = 9'd154; thr_hi_cong = 9'd179;
  endtask

  task automatic run_window(int w);
    int mode, pct, occ_max, busy, osum, lo, hi;
    mode = (w < 8) ? w : 8 + int'($urandom % 2);
    busy = 0; osum = 0;
    set_default_thr();
    link_div = 4'd1;
    pct = int'($urandom % 101);
    occ_max = CAP;
    case (mode)
      0: begin pct = 0;   occ_max = 0;   end           // idle link
      1: begin pct = 100; occ_max = 20;  end           // full link
      2: begin pct = 100; link_div = 4'd4; end         // saturation R8
      3: begin pct = 100; occ_max = 255; end           // clamp R3
      4: begin occ_max = 255; end                      // stays congested
      5: begin thr_lo_light = 9'd0; thr_hi_light = 9'd256;
               thr_lo_cong = 9'd0; thr_hi_cong = 9'd256; end // hold R6
      6: begin pct = 0; occ_max = 0; end               // back to idle R7
      7: begin pct = 50; link_div = 4'd2; occ_max = 60; end
      default: begin
        link_div = 4'(1 + $urandom % 4);
        occ_max  = int'($urandom % (CAP + 60));
        if (mode == 9) begin
          thr_cong     = 9'($urandom % 257);
          thr_lo_light = 9'($urandom % 257);
          thr_hi_light = 9'($urandom % 257);
          thr_lo_cong  = 9'($urandom % 257);
          thr_hi_cong  = 9'($urandom % 257);
        end
      end
    endcase
    for (int i = 0; i < WIN; i++) begin
      int occ;
      if (i == 0 && w > 0) check_boundary();
      if (i > 0) check("R1", "no strobe inside window", int'(req_valid), 0);
      link_flit = (int'($urandom % 100) < pct);
      occ = (occ_max == 0) ? 0 : int'($urandom % (occ_max + 1));
      if (mode == 3 || mode == 4) occ = occ_max;
      buf_occ = 8'(occ);
      if (link_flit) busy++;
      osum += (occ > CAP) ? CAP : occ;
      @(negedge clk);
    end
    m_lu = blend(sample_lu(busy, int'(link_div)), m_lu);
    m_bu = blend(sample_bu(osum), m_bu);
    m_cong = (m_bu >= int'(thr_cong)) ? 1 : 0;
    lo = m_cong ? int'(thr_lo_cong) : int'(thr_lo_light);
    hi = m_cong ? int'(thr_hi_cong) : int'(thr_hi_light);
    m_slow = (m_lu < lo) ? 1 : 0;
    m_fast = (!m_slow && m_lu > hi) ? 1 : 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; link_flit = 1'b0; buf_occ = '0; link_div = 4'd1;
    set_default_thr();
    repeat (3) @(negedge clk);
    check("R1", "reset req_valid", int'(req_valid), 0);
    check("R4", "reset lu_pred", int'(lu_pred), 0);
    check("R4", "reset bu_pred", int'(bu_pred), 0);
    check("R6", "reset step outputs", int'(step_faster) + int'(step_slower), 0);
    check("R5", "reset congested", int'(congested), 0);
    rst_n = 1'b1;
    for (int w = 0; w < NWIN; w++) run_window(w);
    check_boundary();
    @(negedge clk);
    check("R1", "strobe drops after one cycle", int'(req_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule